// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the bookkeeping for up to 256 interrupt vectors next to a processor core. Three bitmaps record which vectors are waiting for service, which are being serviced, and whether each vector last arrived as level- or edge-triggered. Interrupt sources post requests through a valid/ready port carrying a vector number and a trigger kind. The core sees a single request line. It answers with an acknowledge strobe, which returns a vector, and it closes a handler with an end-of-interrupt strobe.

Vector priority is positional: a lower vector number ranks higher. The block also derives a processor priority value from a task-priority register and the most urgent vector in service. Every bitmap can be read one 32-bit word at a time through a combinational read port.

The two priority scans over the 256 bits are registered. The request line and the processor priority therefore reflect bitmap changes one cycle after the bitmaps change. The block also imposes a spacing rule on its strobes. After an acknowledge or end-of-interrupt strobe, the next such strobe must wait at least one idle cycle. An acknowledge only considers requests accepted at least two cycles before it. The request port never applies back-pressure, because `req_ready` is held high and a request is taken on every cycle where `req_valid` is high.

Top module: `irq_prio_tracker`

## Requirements
- R1: `rd_word` shows word `rd_sel` of the bitmap picked by `rd_map` (0 pending, 1 in-service, 2 trigger kind, 3 reads zero), where bit b of word k stands for vector 32k+b; after reset all bitmaps are zero.
- R2: An accepted request sets the vector's pending bit, and sets its trigger bit when `req_level` is 1 or clears it when `req_level` is 0.
- R3: `cpu_irq` is high only when some vector is pending and either no vector is in service or the lowest-numbered pending vector is below the lowest-numbered in-service vector.
- R4: One cycle after an acknowledge strobe, `ack_valid` pulses with `ack_none` low and `ack_vec` set to the lowest-numbered pending vector, which has then moved from pending to in-service.
- R5: An acknowledge with nothing pending answers with `ack_none` high and `ack_vec` zero.
- R6: While `sw_enable` is low, an acknowledge answers with `ack_none` high and leaves the pending and in-service bitmaps unchanged.
- R7: End-of-interrupt clears the lowest-numbered in-service bit; with the in-service set empty it changes nothing.
- R8: `ppr` equals the task-priority register when its class (bits 7:4) is not below the class of the lowest-numbered in-service vector (class 0 when none is in service); otherwise it is that vector's class followed by four zero bits.
- R9: `tpr_nib_wr` loads `tpr_nib_wdata` into task-priority bits 7:4 and clears bits 3:0; `tpr_wr` loads all eight bits and takes precedence; `tpr_nib_rd` always returns bits 7:4.
- R10: A request and an acknowledge in the same cycle for the same vector leave that vector both in service and still pending.
- R11: `req_ready` is high from reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| sw_enable | input | 1 | Software enable for acknowledge |
| ack_pulse | input | 1 | Acknowledge strobe from the core |
| ack_valid | output | 1 | Acknowledge answer, one cycle after strobe |
| ack_none | output | 1 | Answer carries no vector |
| ack_vec | output | 8 | Vector handed to the core |
| eoi_pulse | input | 1 | End-of-interrupt strobe |
| cpu_irq | output | 1 | Interrupt request to the core |
| tpr_wr | input | 1 | Full task-priority write |
| tpr_wdata | input | 8 | Full task-priority value |
| tpr_nib_wr | input | 1 | Task-priority class write |
| tpr_nib_wdata | input | 4 | Task-priority class value |
| tpr_nib_rd | output | 4 | Task-priority class readback |
| ppr | output | 8 | Processor priority |
| rd_map | input | 2 | Bitmap select for readout |
| rd_sel | input | 3 | Word select for readout |
| rd_word | output | 32 | Selected bitmap word |

## Verification
The assertions check several rules on every clock. A request must leave its pending bit set and its trigger bit equal to the kind it carried. An accepted acknowledge must leave its vector in service, and the returned vector must be in service. A disabled acknowledge must leave the pending set untouched. End-of-interrupt on an empty in-service set must keep it empty. The processor priority must never fall below the task priority. The bench scenarios cover what needs the whole order of events. They sweep all 256 vectors through request, acknowledge and retirement in priority order, and they show that the request line is gated by relative rank. They also show that the priority class rises and falls as handlers nest, and that a request colliding with an acknowledge is kept.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int CLASS_SHIFT = 4;

  typedef enum logic [1:0] {
    MAP_PEND = 2'd0,
    MAP_SERV = 2'd1,
    MAP_TRIG = 2'd2,
    MAP_NONE = 2'd3
  } map_sel_e;
endpackage

// File: rtl/ipt_ffs.sv
module ipt_ffs #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ipt_maps.sv
module ipt_maps #(
  parameter int NUM_VEC = 256,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_fire,
  input  logic [VW-1:0]      req_vec,
  input  logic               req_level,
  input  logic               take,
  input  logic [VW-1:0]      take_vec,
  input  logic               retire,
  input  logic [VW-1:0]      retire_vec,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] serv,
  output logic [NUM_VEC-1:0] trig
);
  // retire first, then take, then the new request, so a colliding request survives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      serv <= '0;
      trig <= '0;
    end else begin
      if (retire) serv[retire_vec] <= 1'b0;
      if (take) begin
        pend[take_vec] <= 1'b0;
        serv[take_vec] <= 1'b1;
      end
      if (req_fire) begin
        pend[req_vec] <= 1'b1;
        trig[req_vec] <= req_level;
      end
    end
  end

  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> pend[$past(req_vec)] && (trig[$past(req_vec)] == $past(req_level)));

  p_take_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> serv[$past(take_vec)]);

  p_collide_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_fire && req_vec == take_vec) |=> pend[$past(take_vec)]);
endmodule

// File: rtl/ipt_arbiter.sv
module ipt_arbiter #(
  parameter int NUM_VEC = 256,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] pend,
  input  logic [NUM_VEC-1:0] serv,
  input  logic [VW-1:0]      tpr,
  output logic               pend_found,
  output logic [VW-1:0]      pend_idx,
  output logic               serv_found,
  output logic [VW-1:0]      serv_idx,
  output logic               cpu_irq,
  output logic [VW-1:0]      ppr
);
  import ipt_pkg::*;
  localparam int CW = VW - CLASS_SHIFT;

  logic          p_found_c, s_found_c;
  logic [VW-1:0] p_idx_c, s_idx_c;
  logic [CW-1:0] t_cls, s_cls;

  ipt_ffs #(.N(NUM_VEC), .IW(VW)) u_scan_pend (.bits(pend), .found(p_found_c), .idx(p_idx_c));
  ipt_ffs #(.N(NUM_VEC), .IW(VW)) u_scan_serv (.bits(serv), .found(s_found_c), .idx(s_idx_c));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_found <= 1'b0;
      pend_idx   <= '0;
      serv_found <= 1'b0;
      serv_idx   <= '0;
    end else begin
      pend_found <= p_found_c;
      pend_idx   <= p_idx_c;
      serv_found <= s_found_c;
      serv_idx   <= s_idx_c;
    end
  end

  always_comb begin
    cpu_irq = pend_found && (!serv_found || (pend_idx < serv_idx));
    t_cls   = tpr[VW-1:CLASS_SHIFT];
    s_cls   = serv_found ? serv_idx[VW-1:CLASS_SHIFT] : '0;
    ppr     = (t_cls >= s_cls) ? tpr : {s_cls, {CLASS_SHIFT{1'b0}}};
  end

  p_ppr_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr);
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VW     = $clog2(NUM_VEC),
  localparam int NWORDS = NUM_VEC / WORD_W,
  localparam int SW     = $clog2(NWORDS),
  localparam int CW     = VW - ipt_pkg::CLASS_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VW-1:0]     req_vec,
  input  logic              req_level,
  input  logic              sw_enable,
  input  logic              ack_pulse,
  output logic              ack_valid,
  output logic              ack_none,
  output logic [VW-1:0]     ack_vec,
  input  logic              eoi_pulse,
  output logic              cpu_irq,
  input  logic              tpr_wr,
  input  logic [VW-1:0]     tpr_wdata,
  input  logic              tpr_nib_wr,
  input  logic [CW-1:0]     tpr_nib_wdata,
  output logic [CW-1:0]     tpr_nib_rd,
  output logic [VW-1:0]     ppr,
  input  logic [1:0]        rd_map,
  input  logic [SW-1:0]     rd_sel,
  output logic [WORD_W-1:0] rd_word
);
  import ipt_pkg::*;

  logic [NUM_VEC-1:0] pend_map, serv_map, trig_map, sel_map;
  logic               pend_found, serv_found, take, retire, req_fire;
  logic [VW-1:0]      pend_idx, serv_idx, tpr_q;

  assign req_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;
  assign take      = ack_pulse && sw_enable && pend_found;
  assign retire    = eoi_pulse && serv_found;

  ipt_maps #(.NUM_VEC(NUM_VEC), .VW(VW)) u_maps (
    .clk, .rst_n, .req_fire, .req_vec, .req_level,
    .take, .take_vec(pend_idx), .retire, .retire_vec(serv_idx),
    .pend(pend_map), .serv(serv_map), .trig(trig_map)
  );

  ipt_arbiter #(.NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
    .clk, .rst_n, .pend(pend_map), .serv(serv_map), .tpr(tpr_q),
    .pend_found, .pend_idx, .serv_found, .serv_idx, .cpu_irq, .ppr
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q     <= '0;
      ack_valid <= 1'b0;
      ack_none  <= 1'b0;
      ack_vec   <= '0;
    end else begin
      if (tpr_wr)          tpr_q <= tpr_wdata;
      else if (tpr_nib_wr) tpr_q <= {tpr_nib_wdata, {CLASS_SHIFT{1'b0}}};
      ack_valid <= ack_pulse;
      ack_none  <= !take;
      ack_vec   <= take ? pend_idx : '0;
    end
  end

  assign tpr_nib_rd = tpr_q[VW-1:CLASS_SHIFT];

  always_comb begin
    case (map_sel_e'(rd_map))
      MAP_PEND: sel_map = pend_map;
      MAP_SERV: sel_map = serv_map;
      MAP_TRIG: sel_map = trig_map;
      default:  sel_map = '0;
    endcase
    rd_word = sel_map[int'(rd_sel) * WORD_W +: WORD_W];
  end

  p_ack_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !sw_enable && !req_fire) |=> ack_none && $stable(pend_map));

  p_ack_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_none) |-> serv_map[ack_vec]);

  p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && !ack_pulse && serv_map == '0) |=> serv_map == '0);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

// File: tb/irq_prio_tracker_bench.sv
module irq_prio_tracker_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_level = 0, sw_enable = 0, ack_pulse = 0, eoi_pulse = 0;
  logic        tpr_wr = 0, tpr_nib_wr = 0;
  logic [7:0]  req_vec = 0, tpr_wdata = 0;
  logic [3:0]  tpr_nib_wdata = 0;
  logic [1:0]  rd_map = 0;
  logic [2:0]  rd_sel = 0;
  logic        req_ready, ack_valid, ack_none, cpu_irq;
  logic [7:0]  ack_vec, ppr;
  logic [3:0]  tpr_nib_rd;
  logic [31:0] rd_word;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  irq_prio_tracker u_irq_prio_tracker (
    .clk, .rst_n, .req_valid, .req_ready, .req_vec, .req_level, .sw_enable,
    .ack_pulse, .ack_valid, .ack_none, .ack_vec, .eoi_pulse, .cpu_irq,
    .tpr_wr, .tpr_wdata, .tpr_nib_wr, .tpr_nib_wdata, .tpr_nib_rd, .ppr,
    .rd_map, .rd_sel, .rd_word
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int m, input int s, output logic [31:0] w);
    rd_map = 2'(m); rd_sel = 3'(s); #1; w = rd_word;
  endtask

  task automatic do_req(input int v, input logic l);
    @(negedge clk); req_valid = 1; req_vec = 8'(v); req_level = l;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic v, output logic n, output logic [7:0] vec);
    @(negedge clk); ack_pulse = 1;
    @(negedge clk); ack_pulse = 0; v = ack_valid; n = ack_none; vec = ack_vec;
    @(negedge clk);
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi_pulse = 1;
    @(negedge clk); eoi_pulse = 0;
    @(negedge clk);
  endtask

  task automatic tpr_full(input int v);
    @(negedge clk); tpr_wr = 1; tpr_wdata = 8'(v);
    @(negedge clk); tpr_wr = 0;
  endtask

  function automatic logic [31:0] above(input int b);
    return 32'((64'hFFFF_FFFF << (b + 1)) & 64'hFFFF_FFFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic av, an;
    logic [7:0] vec;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R11 ready", req_ready, 1);
    chk("R3 irq at reset", cpu_irq, 0);
    chk("R8 ppr at reset", ppr, 0);
    chk("R4 ack_valid at reset", ack_valid, 0);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++) begin rd(m, s, w); chk("R1 reset word", w, 0); end
    sw_enable = 1;

    // R2: request every vector, odd ones level-triggered
    for (int v = 0; v < 256; v++) do_req(v, v[0]);
    for (int s = 0; s < 8; s++) begin
      rd(0, s, w); chk("R2 pending full", w, 32'hFFFF_FFFF);
      rd(2, s, w); chk("R2 trigger odd", w, 32'hAAAA_AAAA);
      rd(1, s, w); chk("R1 in-service empty", w, 0);
      rd(3, s, w); chk("R1 select 3 zero", w, 0);
    end
    chk("R3 irq pending only", cpu_irq, 1);
    do_req(3, 1'b0);
    rd(2, 0, w); chk("R2 edge clears trigger", w, 32'hAAAA_AAA2);

    // R4: acknowledge sweep in priority order
    for (int i = 0; i < 256; i++) begin
      do_ack(av, an, vec);
      chk("R4 ack_valid", av, 1);
      chk("R4 ack_none", an, 0);
      chk("R4 ack_vec order", vec, i);
      rd(0, i / 32, w); chk("R4 pending cleared", w, above(i % 32));
      chk("R3 irq blocked by vector 0", cpu_irq, 0);
      chk("R8 ppr class 0", ppr, 0);
    end
    for (int s = 0; s < 8; s++) begin rd(1, s, w); chk("R4 all in service", w, 32'hFFFF_FFFF); end
    do_ack(av, an, vec);
    chk("R5 empty ack none", an, 1);
    chk("R5 empty ack vec", vec, 0);

    // R7 and R8: retire in order, class of best in-service tracks
    for (int i = 0; i < 256; i++) begin
      do_eoi();
      rd(1, i / 32, w); chk("R7 eoi lowest", w, above(i % 32));
      chk("R8 ppr nesting", ppr, (i < 255) ? (((i + 1) >> 4) << 4) : 0);
    end
    do_eoi();
    for (int s = 0; s < 8; s++) begin rd(1, s, w); chk("R7 eoi on empty", w, 0); end

    // R9 class port
    @(negedge clk); tpr_nib_wr = 1; tpr_nib_wdata = 4'h5;
    @(negedge clk); tpr_nib_wr = 0;
    chk("R9 nib readback", tpr_nib_rd, 5);
    chk("R9 nib clears low", ppr, 8'h50);
    @(negedge clk); tpr_nib_wr = 1; tpr_nib_wdata = 4'hC; tpr_wr = 1; tpr_wdata = 8'h37;
    @(negedge clk); tpr_nib_wr = 0; tpr_wr = 0;
    chk("R9 full write wins", tpr_nib_rd, 3);
    chk("R8 ppr equals tpr", ppr, 8'h37);

    // R8 with a vector in service
    do_req(8'h90, 1'b0);
    do_ack(av, an, vec);
    chk("R4 ack 0x90", vec, 8'h90);
    chk("R8 class from in-service", ppr, 8'h90);
    tpr_full(8'hA2); chk("R8 tpr above", ppr, 8'hA2);
    tpr_full(8'h95); chk("R8 equal class keeps tpr", ppr, 8'h95);
    tpr_full(0);

    // R3 gating by rank
    do_req(8'hA0, 1'b0);
    chk("R3 lower rank no irq", cpu_irq, 0);
    do_req(8'h20, 1'b0);
    chk("R3 higher rank irq", cpu_irq, 1);
    do_ack(av, an, vec);
    chk("R4 ack 0x20", vec, 8'h20);
    chk("R3 irq after nesting", cpu_irq, 0);
    do_eoi(); do_eoi();
    chk("R3 irq after retire", cpu_irq, 1);

    // R6 software disable
    sw_enable = 0;
    do_ack(av, an, vec);
    chk("R6 ack none", an, 1);
    rd(0, 5, w); chk("R6 pending kept", w, 1);
    rd(1, 5, w); chk("R6 nothing in service", w, 0);
    sw_enable = 1;

    // R10 colliding request and acknowledge
    @(negedge clk); ack_pulse = 1; req_valid = 1; req_vec = 8'hA0; req_level = 1;
    @(negedge clk); ack_pulse = 0; req_valid = 0;
    chk("R10 ack vector", ack_vec, 8'hA0);
    rd(0, 5, w); chk("R10 still pending", w, 1);
    rd(1, 5, w); chk("R10 in service", w, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule